// File: doc/BRIEF.md
# Processor Mode and Exception Entry Controller

This block keeps the processor's current operating mode together with two interrupt mask bits, and it performs the mode switch when an exception is taken. Each cycle it looks at five entry causes: a memory abort strobe, a fast interrupt request, a normal interrupt request, an undefined-instruction strobe and a software interrupt strobe. An interrupt request is only considered while its mask bit is clear. The block picks one cause by fixed priority. On the next clock edge it switches to that cause's mode, stores the current program counter as the link value, saves the previous mode and masks, and presents the cause's vector address with a one-cycle entry pulse.

A return strobe puts back the saved mode and masks in a single cycle, so the sequencer around the block can leave a handler. The synchronous reset is the strongest cause. It forces Supervisor mode with both masks set. It also preloads the saved context with unprivileged User mode and clear masks, so the first return after reset moves the core into User mode with interrupts enabled. The privileged flag tells the rest of the core whether the current mode is allowed protected operations.

Top module: `exc_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block moves to Supervisor mode (`10011`) with both masks set, vector `VEC_BASE+0x00`, link 0, entry pulse low, and saved context User (`10000`) with both masks clear.
- R2: Modes on `mode_o` use these 5-bit codes: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undef 11011, System 11111.
- R3: When several causes are present in the same cycle, the winner is chosen in this order: abort, then fast interrupt, then normal interrupt, then undefined instruction, then software interrupt.
- R4: A fast interrupt entry selects mode 10001, sets both masks and presents vector `VEC_BASE+0x1C`.
- R5: A normal interrupt entry selects mode 10010, sets the IRQ mask, leaves the FIQ mask unchanged and presents vector `VEC_BASE+0x18`.
- R6: An abort enters mode 10111 with vector `+0x10`. An undefined instruction enters 11011 with vector `+0x04`. A software interrupt enters 10011 with vector `+0x08`. Each of these sets the IRQ mask and keeps the FIQ mask.
- R7: A fast or normal interrupt request is ignored while its own mask bit is set, and the next lower-priority cause is taken in its place.
- R8: One cycle after a cause is accepted, `entry_o` is high for that single cycle and `link_o` holds the `pc_in` value from the accepting cycle. `vec_o` and `link_o` keep their values until the next entry.
- R9: On entry, the previous mode and both masks are saved and `saved_mode_o` shows the saved mode. A return strobe with no cause present restores the saved mode and masks at the next edge. An accepted cause takes precedence over a return in the same cycle.
- R10: `priv_o` is low in User mode and high in every other mode.
- R11: In a cycle with no accepted cause and no return, mode, masks, saved context, vector and link all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strongest entry cause |
| abt_stb | input | 1 | Memory access violation strobe |
| fiq_req | input | 1 | Fast interrupt request (level) |
| irq_req | input | 1 | Normal interrupt request (level) |
| und_stb | input | 1 | Undefined instruction strobe |
| swi_stb | input | 1 | Software interrupt strobe |
| ret_stb | input | 1 | Return-from-exception strobe |
| pc_in | input | AW | Current program counter |
| mode_o | output | 5 | Current mode code |
| priv_o | output | 1 | High in any mode other than User |
| fiq_mask_o | output | 1 | Fast interrupt mask |
| irq_mask_o | output | 1 | Normal interrupt mask |
| entry_o | output | 1 | One-cycle pulse after an exception is taken |
| vec_o | output | AW | Vector address of the most recent entry |
| link_o | output | AW | Program counter saved at the most recent entry |
| saved_mode_o | output | 5 | Mode that a return will restore |

## Verification
The assertions assume that all strobes are synchronous to `clk` and that `pc_in` is stable at each sampling edge. They also assume that a request whose mask is set must never produce the vector of its own cause. The bench therefore drives every input just after a falling edge and keeps it for a whole cycle. Directed sequences cover each cause alone, every priority pairing, a blocked request under both masks, and a return racing an entry. A long stretch of sparse pseudo-random strobes and returns, with occasional resets, then checks mode, masks, saved context, vector and link against a behavioural model on every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [4:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        CS_NONE = 3'd0,
        CS_ABT  = 3'd1,
        CS_FIQ  = 3'd2,
        CS_IRQ  = 3'd3,
        CS_UND  = 3'd4,
        CS_SWI  = 3'd5
    } cause_e;

    // number of arbitrated causes (reset is handled by the register stage)
    localparam int NCAUSE = 5;

    typedef struct packed {
        mode_e mode;
        logic  fmask;
        logic  imask;
    } ctx_t;

    function automatic mode_e cause_mode(input cause_e c);
        case (c)
            CS_ABT:  return MD_ABT;
            CS_FIQ:  return MD_FIQ;
            CS_IRQ:  return MD_IRQ;
            CS_UND:  return MD_UND;
            default: return MD_SVC;
        endcase
    endfunction

    function automatic logic [4:0] cause_offset(input cause_e c);
        case (c)
            CS_ABT:  return 5'h10;
            CS_FIQ:  return 5'h1C;
            CS_IRQ:  return 5'h18;
            CS_UND:  return 5'h04;
            CS_SWI:  return 5'h08;
            default: return 5'h00;
        endcase
    endfunction

    function automatic logic is_priv(input mode_e m);
        return m != MD_USR;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   abt_stb,
    input  logic   fiq_req,
    input  logic   irq_req,
    input  logic   und_stb,
    input  logic   swi_stb,
    input  logic   fmask,
    input  logic   imask,
    output cause_e cause
);
    // index 0 is the strongest cause
    logic [NCAUSE-1:0] pend;
    int                win;

    assign pend = {swi_stb, und_stb, irq_req & ~imask, fiq_req & ~fmask, abt_stb};

    always_comb begin
        win = NCAUSE;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (pend[i]) win = i;
        end
        case (win)
            0:       cause = CS_ABT;
            1:       cause = CS_FIQ;
            2:       cause = CS_IRQ;
            3:       cause = CS_UND;
            4:       cause = CS_SWI;
            default: cause = CS_NONE;
        endcase
    end
endmodule

// File: rtl/exc_vector_map.sv
module exc_vector_map
    import exc_pkg::*;
#(
    parameter int             AW       = 32,
    parameter logic [AW-1:0]  VEC_BASE = '0
) (
    input  cause_e        cause,
    input  ctx_t          cur,
    output logic          take,
    output ctx_t          nxt,
    output logic [AW-1:0] vec
);
    localparam int OFFW = 5;

    assign take      = (cause != CS_NONE);
    assign nxt.mode  = cause_mode(cause);
    assign nxt.fmask = (cause == CS_FIQ) ? 1'b1 : cur.fmask;
    assign nxt.imask = 1'b1;
    assign vec       = VEC_BASE + {{(AW-OFFW){1'b0}}, cause_offset(cause)};
endmodule

// File: rtl/exc_mode_regs.sv
module exc_mode_regs
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          ret_stb,
    input  ctx_t          nxt,
    input  logic [AW-1:0] vec_in,
    input  logic [AW-1:0] pc_in,
    output ctx_t          cur,
    output ctx_t          saved,
    output logic [AW-1:0] vec_q,
    output logic [AW-1:0] link_q,
    output logic          entry_q
);
    localparam ctx_t CTX_RST  = '{mode: MD_SVC, fmask: 1'b1, imask: 1'b1};
    localparam ctx_t CTX_SRST = '{mode: MD_USR, fmask: 1'b0, imask: 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= CTX_RST;
            saved   <= CTX_SRST;
            vec_q   <= VEC_BASE;
            link_q  <= '0;
            entry_q <= 1'b0;
        end else if (take) begin
            saved   <= cur;
            cur     <= nxt;
            vec_q   <= vec_in;
            link_q  <= pc_in;
            entry_q <= 1'b1;
        end else begin
            entry_q <= 1'b0;
            if (ret_stb) cur <= saved;
        end
    end
endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abt_stb,
    input  logic          fiq_req,
    input  logic          irq_req,
    input  logic          und_stb,
    input  logic          swi_stb,
    input  logic          ret_stb,
    input  logic [AW-1:0] pc_in,
    output logic [4:0]    mode_o,
    output logic          priv_o,
    output logic          fiq_mask_o,
    output logic          irq_mask_o,
    output logic          entry_o,
    output logic [AW-1:0] vec_o,
    output logic [AW-1:0] link_o,
    output logic [4:0]    saved_mode_o
);
    cause_e        cause;
    ctx_t          cur;
    ctx_t          saved;
    ctx_t          nxt;
    logic          take;
    logic [AW-1:0] vec_next;

    exc_arbiter u_arb (
        .abt_stb (abt_stb),
        .fiq_req (fiq_req),
        .irq_req (irq_req),
        .und_stb (und_stb),
        .swi_stb (swi_stb),
        .fmask   (cur.fmask),
        .imask   (cur.imask),
        .cause   (cause)
    );

    exc_vector_map #(.AW(AW), .VEC_BASE(VEC_BASE)) u_map (
        .cause (cause),
        .cur   (cur),
        .take  (take),
        .nxt   (nxt),
        .vec   (vec_next)
    );

    exc_mode_regs #(.AW(AW), .VEC_BASE(VEC_BASE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .ret_stb (ret_stb),
        .nxt     (nxt),
        .vec_in  (vec_next),
        .pc_in   (pc_in),
        .cur     (cur),
        .saved   (saved),
        .vec_q   (vec_o),
        .link_q  (link_o),
        .entry_q (entry_o)
    );

    assign mode_o       = cur.mode;
    assign priv_o       = is_priv(cur.mode);
    assign fiq_mask_o   = cur.fmask;
    assign irq_mask_o   = cur.imask;
    assign saved_mode_o = saved.mode;
endmodule

// File: rtl/exc_mode_ctrl_chk.sv
module exc_mode_ctrl_chk #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          abt_stb,
    input logic          fiq_req,
    input logic          irq_req,
    input logic          und_stb,
    input logic          swi_stb,
    input logic          ret_stb,
    input logic [AW-1:0] pc_in,
    input logic [4:0]    mode_o,
    input logic          priv_o,
    input logic          fiq_mask_o,
    input logic          irq_mask_o,
    input logic          entry_o,
    input logic [AW-1:0] vec_o,
    input logic [AW-1:0] link_o,
    input logic [4:0]    saved_mode_o
);
    localparam logic [AW-1:0] V_FIQ = VEC_BASE + AW'(28);
    localparam logic [AW-1:0] V_IRQ = VEC_BASE + AW'(24);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: one cycle after reset the block sits in Supervisor with both masks set
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            assert_reset_state_R1: assert (mode_o == 5'b10011 && fiq_mask_o && irq_mask_o && !entry_o);
    end

    // R8: link captures the program counter of the accepting cycle
    assert_link_capture_R8: assert property (@(posedge clk) disable iff (rst)
        entry_o |-> link_o == $past(pc_in));

    // R4: a fast interrupt entry leaves both masks set
    assert_fiq_masks_R4: assert property (@(posedge clk) disable iff (rst)
        (entry_o && vec_o == V_FIQ) |-> (fiq_mask_o && irq_mask_o && mode_o == 5'b10001));

    // R7: a masked fast interrupt never yields its own vector
    assert_fiq_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        fiq_mask_o |=> !(entry_o && vec_o == V_FIQ));

    // R7: a masked normal interrupt never yields its own vector
    assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        irq_mask_o |=> !(entry_o && vec_o == V_IRQ));

    // R9: a return with no cause restores the saved mode
    assert_return_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_stb && !abt_stb && !und_stb && !swi_stb
         && !(fiq_req && !fiq_mask_o) && !(irq_req && !irq_mask_o))
        |=> (mode_o == $past(saved_mode_o) && !entry_o));

    // R10: every entry lands in a privileged mode with the IRQ mask set
    assert_entry_priv_R10: assert property (@(posedge clk) disable iff (rst)
        entry_o |-> (priv_o && irq_mask_o));

    // R8: the entry pulse lasts one cycle unless a new cause was accepted
    assert_entry_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (entry_o && !abt_stb && !und_stb && !swi_stb
         && !(fiq_req && !fiq_mask_o) && !(irq_req && !irq_mask_o)) |=> !entry_o);
endmodule

bind exc_mode_ctrl exc_mode_ctrl_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/sim_exc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_exc_mode_ctrl;
    localparam int AW = 32;
    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, abt = 0, fiq = 0, irq = 0, und = 0, swi = 0, ret = 0;
    logic [AW-1:0] pc = '0;
    logic [4:0]    mode_o, saved_mode_o;
    logic          priv_o, fiq_mask_o, irq_mask_o, entry_o;
    logic [AW-1:0] vec_o, link_o;

    exc_mode_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .abt_stb(abt), .fiq_req(fiq), .irq_req(irq),
        .und_stb(und), .swi_stb(swi), .ret_stb(ret), .pc_in(pc),
        .mode_o(mode_o), .priv_o(priv_o), .fiq_mask_o(fiq_mask_o),
        .irq_mask_o(irq_mask_o), .entry_o(entry_o), .vec_o(vec_o),
        .link_o(link_o), .saved_mode_o(saved_mode_o));

    // behavioural reference state
    logic [4:0]    e_mode = M_SVC, e_smode = M_USR;
    logic          e_fm = 1, e_im = 1, e_sfm = 0, e_sim = 0, e_ent = 0;
    logic [AW-1:0] e_vec = '0, e_link = '0;

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic model_edge();
        if (rst) begin
            e_mode = M_SVC; e_fm = 1; e_im = 1; e_smode = M_USR; e_sfm = 0; e_sim = 0;
            e_vec = '0; e_link = '0; e_ent = 0;
        end else begin
            logic [4:0] nm; logic [AW-1:0] nv; bit hit; bit isf;
            hit = 1; isf = 0; nm = M_SVC; nv = '0;
            if (abt)                begin nm = M_ABT; nv = 32'h10; end
            else if (fiq && !e_fm)  begin nm = M_FIQ; nv = 32'h1C; isf = 1; end
            else if (irq && !e_im)  begin nm = M_IRQ; nv = 32'h18; end
            else if (und)           begin nm = M_UND; nv = 32'h04; end
            else if (swi)           begin nm = M_SVC; nv = 32'h08; end
            else hit = 0;
            if (hit) begin
                e_smode = e_mode; e_sfm = e_fm; e_sim = e_im;
                e_mode = nm; if (isf) e_fm = 1; e_im = 1;
                e_vec = nv; e_link = pc; e_ent = 1;
            end else begin
                e_ent = 0;
                if (ret) begin e_mode = e_smode; e_fm = e_sfm; e_im = e_sim; end
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [12:0] act, exp;
        act = {mode_o, saved_mode_o, fiq_mask_o, irq_mask_o, entry_o};
        exp = {e_mode, e_smode, e_fm, e_im, e_ent};
        total++;
        if (act !== exp || vec_o !== e_vec || link_o !== e_link || priv_o !== (e_mode != M_USR)) begin
            bad++;
            $display("FAIL %s: act ctl=%h vec=%h link=%h priv=%b  exp ctl=%h vec=%h link=%h priv=%b",
                     tag, act, vec_o, link_o, priv_o, exp, e_vec, e_link, e_mode != M_USR);
        end
    endtask

    // drive at negedge, advance one edge, compare at the following negedge
    task automatic step(input logic a, f, i, u, s, r, input logic [AW-1:0] p, input string tag);
        abt = a; fiq = f; irq = i; und = u; swi = s; ret = r; pc = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        step(0,0,0,0,0,0, 32'h0, "R1 reset");
        step(0,0,0,0,0,0, 32'h0, "R1 reset held");
        rst = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        step(0,0,0,0,0,0, 32'h100, "R1 R11 idle after reset");
        step(0,1,1,0,0,0, 32'h104, "R7 both masked in Supervisor");
        step(0,0,0,0,0,1, 32'h108, "R9 return to User");
        step(0,0,0,0,0,0, 32'h10C, "R10 User unprivileged");
        step(0,0,1,0,0,0, 32'h200, "R5 IRQ entry");
        step(0,0,1,0,0,0, 32'h204, "R7 IRQ masked, R8 pulse drop");
        step(0,1,1,0,0,0, 32'h208, "R4 FIQ entry over masked IRQ");
        step(0,1,0,0,0,0, 32'h20C, "R7 FIQ masked");
        step(0,0,0,0,0,1, 32'h210, "R9 return to IRQ");
        step(0,0,0,0,0,1, 32'h214, "R9 second return");
        step(0,0,0,0,0,0, 32'h218, "R11 hold");
        do_reset();
        step(0,0,0,0,0,1, 32'h0, "R9 to User");
        step(1,1,1,1,1,0, 32'h300, "R3 abort wins");
        step(0,0,0,0,0,1, 32'h304, "R9 back");
        step(0,1,1,1,1,0, 32'h308, "R3 FIQ wins");
        step(0,0,0,0,0,1, 32'h30C, "R9 back");
        step(0,0,1,1,1,0, 32'h310, "R3 IRQ wins");
        step(0,0,0,0,0,1, 32'h314, "R9 back");
        step(0,0,0,1,1,0, 32'h318, "R3 R6 Undef wins");
        step(0,0,0,0,0,1, 32'h31C, "R9 back");
        step(0,0,0,0,1,0, 32'h320, "R6 software interrupt");
        step(0,0,0,1,0,1, 32'h324, "R9 entry beats return");
        step(1,0,0,0,0,0, 32'h328, "R6 abort nested");
        step(0,0,0,0,0,1, 32'h32C, "R9 return to Undef");
        step(0,0,0,0,0,0, 32'h330, "R2 R11 hold");
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            rst = (($urandom % 200) == 0);
            step(($urandom % 23) == 0, ($urandom % 7) == 0, ($urandom % 5) == 0,
                 ($urandom % 17) == 0, ($urandom % 13) == 0, r < 8'd60,
                 $urandom, "R3 random mix");
        end
        rst = 0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule